// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry and Exit Controller

This block decides, separately for each chip select of an SDRAM interface, when the memory is placed into self-refresh and when it is brought back out. Four entry triggers are merged. The first is a per-chip-select software request. The second is a warm reset event, which counts only when its enable is set. The third is the rising edge of a power-manager idle request, which also counts only when its enable is set. The fourth is an inactivity timeout. It fires after a programmable number of cycles without bus activity, and only while the clock-control field selects automatic mode (value 2).

Exit from self-refresh is caused by a per-chip-select software exit command or by a read/write access aimed at that chip select. The access is held with ready low until the exit has finished. Each entry or exit is handed to a command sequencer as a valid/direction pair and completes when the sequencer returns done.

The block also answers the power manager's idle request with an acknowledge. It does so only in smart-idle mode (idle-mode field value 2), with no interrupt left unacknowledged and no internal activity pending.

Each chip select runs one state machine with four states:
- IDLE (code 0): normal operation.
- ENTERING (code 1): an entry command is outstanding.
- IN_SR (code 2): the memory is in self-refresh.
- EXITING (code 3): an exit command is outstanding.

Its transitions are:
- IDLE→ENTERING on any enabled entry trigger.
- ENTERING→IN_SR on done.
- IN_SR→EXITING on a software exit or an access request.
- EXITING→IDLE on done.

Top module: `sr_entry_ctrl`

## Requirements
- R1: After reset every chip select is in IDLE (code 0), no sequencer command is valid, every `acc_ready` bit is 1 and `idle_ack` is 0.
- R2: A pulse on `sw_enter[i]` in IDLE moves chip select i to ENTERING (code 1) at the next edge; other chip selects are unchanged. While in ENTERING, `seq_valid[i]`=1 and `seq_enter[i]`=1.
- R3: A pulse on `warm_evt` moves every IDLE chip select to ENTERING when `warm_en`=1, and has no effect when `warm_en`=0.
- R4: A rising edge of `idle_req` moves every IDLE chip select to ENTERING when `idle_en`=1, and has no effect when `idle_en`=0.
- R5: With `clk_mode`=2 and `idle_limit`=N>0, the state machines move IDLE→ENTERING at the Nth consecutive clock edge that sees `bus_active`=0. Any edge with `bus_active`=1 restarts the count. The count then saturates, so the idle period causes only one entry. With any other `clk_mode` value no timeout entry occurs.
- R6: `seq_done[i]` moves chip select i from ENTERING to IN_SR (code 2) and from EXITING to IDLE.
- R7: A pulse on `sw_exit[i]` in IN_SR moves chip select i to EXITING (code 3), where `seq_valid[i]`=1 and `seq_enter[i]`=0.
- R8: `acc_req[i]` in IN_SR moves chip select i to EXITING. `acc_ready[i]` is 1 only in IDLE, so an access is held until the exit completes.
- R9: Entry triggers arriving in ENTERING or EXITING are ignored, and entry triggers arriving in IN_SR are also ignored.
- R10: `idle_ack` rises one edge after all of the following hold together, and falls one edge after any of them fails:
  - `idle_req`=1
  - `idle_mode`=2
  - `irq_busy`=0
  - no chip select is in ENTERING or EXITING
  - no access is waiting with ready low

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_mode | input | 2 | Clock-control field; 2 enables the inactivity timeout |
| idle_mode | input | 2 | Idle-mode field; 2 selects smart idle |
| warm_en | input | 1 | Enables entry on a warm reset event |
| idle_en | input | 1 | Enables entry on a power-manager idle request |
| idle_limit | input | TMR_W | Inactivity cycles before automatic entry; 0 disables |
| sw_enter | input | NUM_CS | Software entry request per chip select (pulse) |
| sw_exit | input | NUM_CS | Software exit command per chip select (pulse) |
| warm_evt | input | 1 | Warm reset event (pulse) |
| idle_req | input | 1 | Idle request from the power manager (level) |
| bus_active | input | 1 | Interconnect activity indication |
| acc_req | input | NUM_CS | Read/write access request per chip select |
| acc_ready | output | NUM_CS | Access may proceed |
| irq_busy | input | 1 | An asserted interrupt is still unacknowledged |
| seq_valid | output | NUM_CS | Command to the sequencer is outstanding |
| seq_enter | output | NUM_CS | Command direction: 1 enter, 0 exit |
| seq_done | input | NUM_CS | Sequencer has finished the command |
| sr_state | output | 2*NUM_CS | State code per chip select, chip select i at bits [2i+1:2i] |
| idle_ack | output | 1 | Idle acknowledge to the power manager |

## Verification
The bench builds the block with NUM_CS=2 and TMR_W=4. Two chip selects make it possible to show that a per-select command leaves the neighbour untouched, while the shared triggers move both at once. The 4-bit counter with a limit of 4 keeps the inactivity window short enough to cover several cases in a few dozen cycles: the restart on activity, the single entry per idle period after saturation, and the absence of entry in a different clock mode.

// File: rtl/sr_pkg.sv
package sr_pkg;
    typedef enum logic [1:0] {
        SR_IDLE     = 2'd0,
        SR_ENTERING = 2'd1,
        SR_IN       = 2'd2,
        SR_EXITING  = 2'd3
    } sr_state_t;

    localparam logic [1:0] CLK_MODE_AUTO  = 2'd2;
    localparam logic [1:0] IDLE_MODE_SMART = 2'd2;
endpackage

// File: rtl/sr_idle_timer.sv
module sr_idle_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_mode,
    input  logic             bus_active,
    input  logic [TMR_W-1:0] limit,
    output logic             hit
);
    import sr_pkg::*;

    logic [TMR_W-1:0] cnt;
    logic             armed;

    assign armed = (clk_mode == CLK_MODE_AUTO) && !bus_active && (limit != '0);
    // Hit on the edge that brings the count to the limit.
    assign hit   = armed && (cnt == limit - TMR_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (bus_active || clk_mode != CLK_MODE_AUTO) begin
            cnt <= '0;
        end else if (cnt != limit) begin
            cnt <= cnt + TMR_W'(1);
        end
    end

    // Once the limit is reached during idle, the count stays put.
    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cnt == limit) |=> $stable(cnt));
    // Activity always restarts the count.
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |=> (cnt == '0));
endmodule

// File: rtl/sr_cs_fsm.sv
module sr_cs_fsm (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_trig,
    input  logic              exit_cmd,
    input  logic              acc_req,
    input  logic              done,
    output sr_pkg::sr_state_t state,
    output logic              cmd_valid,
    output logic              cmd_enter,
    output logic              acc_ready
);
    import sr_pkg::*;

    sr_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            SR_IDLE:     if (enter_trig)          nxt = SR_ENTERING;
            SR_ENTERING: if (done)                nxt = SR_IN;
            SR_IN:       if (exit_cmd || acc_req) nxt = SR_EXITING;
            SR_EXITING:  if (done)                nxt = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SR_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_enter = 1'b0;
        acc_ready = 1'b0;
        unique case (state)
            SR_IDLE:     acc_ready = 1'b1;
            SR_ENTERING: begin cmd_valid = 1'b1; cmd_enter = 1'b1; end
            SR_IN:       ;
            SR_EXITING:  cmd_valid = 1'b1;
        endcase
    end

    assert_enter_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SR_ENTERING && done) |=> (state == SR_IN));
    assert_exit_on_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SR_IN && acc_req) |=> (state == SR_EXITING));
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SR_EXITING && !done) |=> (state == SR_EXITING));
endmodule

// File: rtl/sr_idle_ack.sv
module sr_idle_ack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req,
    input  logic [1:0] idle_mode,
    input  logic       irq_busy,
    input  logic       busy,
    output logic       idle_ack
);
    import sr_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_ack <= 1'b0;
        else        idle_ack <= idle_req && (idle_mode == IDLE_MODE_SMART)
                                && !irq_busy && !busy;
    end

    assert_ack_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req |=> !idle_ack);
    assert_ack_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_busy |=> !idle_ack);
endmodule

// File: rtl/sr_entry_ctrl.sv
module sr_entry_ctrl #(
    parameter int NUM_CS = 2,
    parameter int TMR_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            clk_mode,
    input  logic [1:0]            idle_mode,
    input  logic                  warm_en,
    input  logic                  idle_en,
    input  logic [TMR_W-1:0]      idle_limit,
    input  logic [NUM_CS-1:0]     sw_enter,
    input  logic [NUM_CS-1:0]     sw_exit,
    input  logic                  warm_evt,
    input  logic                  idle_req,
    input  logic                  bus_active,
    input  logic [NUM_CS-1:0]     acc_req,
    output logic [NUM_CS-1:0]     acc_ready,
    input  logic                  irq_busy,
    output logic [NUM_CS-1:0]     seq_valid,
    output logic [NUM_CS-1:0]     seq_enter,
    input  logic [NUM_CS-1:0]     seq_done,
    output logic [2*NUM_CS-1:0]   sr_state,
    output logic                  idle_ack
);
    import sr_pkg::*;

    logic              idle_req_q;
    logic              timeout_hit;
    logic              shared_trig;
    logic [NUM_CS-1:0] in_flight;
    logic              busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_req_q <= 1'b0;
        else        idle_req_q <= idle_req;
    end

    sr_idle_timer #(.TMR_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_mode   (clk_mode),
        .bus_active (bus_active),
        .limit      (idle_limit),
        .hit        (timeout_hit)
    );

    assign shared_trig = (warm_evt && warm_en)
                       || (idle_req && !idle_req_q && idle_en)
                       || timeout_hit;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        sr_state_t st;

        sr_cs_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .enter_trig (sw_enter[i] || shared_trig),
            .exit_cmd   (sw_exit[i]),
            .acc_req    (acc_req[i]),
            .done       (seq_done[i]),
            .state      (st),
            .cmd_valid  (seq_valid[i]),
            .cmd_enter  (seq_enter[i]),
            .acc_ready  (acc_ready[i])
        );

        assign sr_state[2*i +: 2] = st;
        assign in_flight[i] = seq_valid[i];
    end

    assign busy = (|in_flight) || (|(acc_req & ~acc_ready));

    sr_idle_ack u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_req  (idle_req),
        .idle_mode (idle_mode),
        .irq_busy  (irq_busy),
        .busy      (busy),
        .idle_ack  (idle_ack)
    );

    // No acknowledge while a command to the sequencer is outstanding.
    assert_ack_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|seq_valid) |=> !idle_ack);
endmodule

// File: tb/sr_entry_ctrl_test.sv
module sr_entry_ctrl_test;
    localparam int NCS = 2;
    localparam int TW  = 4;
    localparam logic [1:0] ST_IDLE = 2'd0, ST_ENT = 2'd1, ST_IN = 2'd2, ST_EXIT = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] clk_mode = 2'd0, idle_mode = 2'd0;
    logic warm_en = 1'b0, idle_en = 1'b0;
    logic [TW-1:0] idle_limit = 4'd4;
    logic [NCS-1:0] sw_enter = '0, sw_exit = '0, acc_req = '0, seq_done = '0;
    logic warm_evt = 1'b0, idle_req = 1'b0, bus_active = 1'b0, irq_busy = 1'b0;
    logic [NCS-1:0] acc_ready, seq_valid, seq_enter;
    logic [2*NCS-1:0] sr_state;
    logic idle_ack;

    always #4 clk = ~clk;

    sr_entry_ctrl #(.NUM_CS(NCS), .TMR_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .idle_mode(idle_mode),
        .warm_en(warm_en), .idle_en(idle_en), .idle_limit(idle_limit),
        .sw_enter(sw_enter), .sw_exit(sw_exit), .warm_evt(warm_evt),
        .idle_req(idle_req), .bus_active(bus_active), .acc_req(acc_req),
        .acc_ready(acc_ready), .irq_busy(irq_busy), .seq_valid(seq_valid),
        .seq_enter(seq_enter), .seq_done(seq_done), .sr_state(sr_state),
        .idle_ack(idle_ack)
    );

    typedef struct { int cs; logic [1:0] st; string tag; } exp_t;
    exp_t q[$];
    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic expect_st(int cs, logic [1:0] st, string tag);
        exp_t e;
        e.cs = cs; e.st = st; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic expect_both(logic [1:0] st, string tag);
        expect_st(0, st, tag);
        expect_st(1, st, tag);
    endtask

    task automatic chk(int got, int exp, string tag);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Monitor: compares queued expectations shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(int'(sr_state[2*e.cs +: 2]), int'(e.st), e.tag);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk(int'(sr_state), 0, "R1 state");
        chk(int'(seq_valid), 0, "R1 seq_valid");
        chk(int'(acc_ready), 3, "R1 acc_ready");
        chk(int'(idle_ack), 0, "R1 idle_ack");

        // R2 per-CS software entry
        sw_enter = 2'b01;
        expect_st(0, ST_ENT, "R2 cs0 enter"); expect_st(1, ST_IDLE, "R2 cs1 untouched");
        cyc(); sw_enter = '0;
        chk(int'(seq_valid), 1, "R2 seq_valid");
        chk(int'(seq_enter[0]), 1, "R2 seq_enter");
        chk(int'(acc_ready[0]), 0, "R8 ready low in ENTERING");
        expect_st(0, ST_ENT, "R6 waits for done");
        cyc(); seq_done = 2'b01;
        expect_st(0, ST_IN, "R6 enter done");
        cyc(); seq_done = '0; sw_enter = 2'b01;
        expect_st(0, ST_IN, "R9 entry ignored in IN_SR");
        cyc(); sw_enter = '0;
        // R7 software exit
        sw_exit = 2'b01;
        expect_st(0, ST_EXIT, "R7 sw exit");
        cyc(); sw_exit = '0;
        chk(int'(seq_valid[0]), 1, "R7 seq_valid");
        chk(int'(seq_enter[0]), 0, "R7 exit direction");
        sw_enter = 2'b01;
        expect_st(0, ST_EXIT, "R9 entry ignored in EXITING");
        cyc(); sw_enter = '0; seq_done = 2'b01;
        expect_st(0, ST_IDLE, "R6 exit done");
        cyc(); seq_done = '0;

        // R3 warm reset
        warm_evt = 1'b1;
        expect_both(ST_IDLE, "R3 warm disabled");
        cyc(); warm_evt = 1'b0; warm_en = 1'b1;
        cyc(); warm_evt = 1'b1;
        expect_both(ST_ENT, "R3 warm enabled");
        cyc(); warm_evt = 1'b0; seq_done = 2'b11;
        expect_both(ST_IN, "R6 both in SR");
        cyc(); seq_done = '0; warm_en = 1'b0;

        // R8 access exit on cs1
        acc_req = 2'b10;
        expect_st(1, ST_EXIT, "R8 access exit"); expect_st(0, ST_IN, "R8 cs0 stays");
        cyc();
        chk(int'(acc_ready[1]), 0, "R8 access held");
        seq_done = 2'b10;
        expect_st(1, ST_IDLE, "R8 exit complete");
        cyc(); seq_done = '0;
        chk(int'(acc_ready[1]), 1, "R8 access released");
        acc_req = '0; sw_exit = 2'b01;
        expect_st(0, ST_EXIT, "R7 cs0 exit");
        cyc(); sw_exit = '0; seq_done = 2'b01;
        expect_st(0, ST_IDLE, "R6 cs0 back");
        cyc(); seq_done = '0;

        // R4 idle request
        idle_req = 1'b1;
        expect_both(ST_IDLE, "R4 idle disabled");
        cyc(); idle_req = 1'b0;
        cyc(); idle_en = 1'b1; idle_req = 1'b1;
        expect_both(ST_ENT, "R4 idle enabled");
        cyc(); idle_mode = 2'd2;
        expect_both(ST_ENT, "R4 level held");
        cyc();
        chk(int'(idle_ack), 0, "R10 no ack while entering");
        seq_done = 2'b11;
        expect_both(ST_IN, "R6 idle entry done");
        cyc(); seq_done = '0;
        cyc();
        chk(int'(idle_ack), 1, "R10 ack given");
        irq_busy = 1'b1;
        cyc();
        chk(int'(idle_ack), 0, "R10 irq blocks ack");
        irq_busy = 1'b0; idle_mode = 2'd1;
        cyc();
        chk(int'(idle_ack), 0, "R10 wrong idle mode");
        idle_mode = 2'd2;
        cyc();
        chk(int'(idle_ack), 1, "R10 ack again");
        idle_req = 1'b0;
        cyc();
        chk(int'(idle_ack), 0, "R10 ack drops");
        idle_en = 1'b0; sw_exit = 2'b11;
        expect_both(ST_EXIT, "R7 both exit");
        cyc(); sw_exit = '0; seq_done = 2'b11;
        expect_both(ST_IDLE, "R6 both idle");
        cyc(); seq_done = '0;

        // R5 inactivity timeout
        clk_mode = 2'd2; bus_active = 1'b1;
        cyc(); bus_active = 1'b0;
        for (int k = 0; k < 3; k++) begin expect_both(ST_IDLE, "R5 counting"); cyc(); end
        bus_active = 1'b1;
        expect_both(ST_IDLE, "R5 reload");
        cyc(); bus_active = 1'b0;
        for (int k = 0; k < 3; k++) begin expect_both(ST_IDLE, "R5 recount"); cyc(); end
        expect_both(ST_ENT, "R5 timeout entry");
        cyc(); seq_done = 2'b11;
        expect_both(ST_IN, "R6 timeout entry done");
        cyc(); seq_done = '0; sw_exit = 2'b11;
        expect_both(ST_EXIT, "R7 exit after timeout");
        cyc(); sw_exit = '0; seq_done = 2'b11;
        expect_both(ST_IDLE, "R6 idle after timeout");
        cyc(); seq_done = '0;
        for (int k = 0; k < 6; k++) begin expect_both(ST_IDLE, "R5 once per idle period"); cyc(); end
        clk_mode = 2'd1; bus_active = 1'b1;
        cyc(); bus_active = 1'b0;
        for (int k = 0; k < 7; k++) begin expect_both(ST_IDLE, "R5 other clock mode"); cyc(); end

        cyc(); cyc();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule